// File: doc/BRIEF.md
# Power-Series Discrete Integrator

This block forms a discrete sum of polynomial terms over an unsigned 16-bit integer variable. A caller loads a first value, a last value, a single evaluation point, a four-bit term selection and a mode bit, then pulses `start`. In sweep mode the block steps the variable through every integer from the first value to the last value, one value per clock. In point mode it evaluates the selected terms once, at the evaluation point. In both modes the sum of the selected powers (x, x², x³, x⁴) for each value is added into a 200-bit running total.

The powers come from one chain of three multipliers. The first multiplier squares x. The second multiplies the square by x to give the cube. The third squares the square to give the fourth power. The term sum for each value is registered before it reaches the wide accumulator. A new task adds on top of the previous total. Pulsing `finish` empties the total, and a one-cycle `done` pulse marks the end of each task.

Top module: `pwr_series_integ`

## Requirements
- R1: While reset is low, and on the first clock after it is released, `result` is 0 and `done` is 0.
- R2: The selection bit `term_sel[0]` enables the x term, `term_sel[1]` enables x², `term_sel[2]` enables x³ and `term_sel[3]` enables x⁴. Any combination may be set, and a term whose bit is 0 adds nothing. With all bits 0, a task adds 0.
- R3: With `mode` = 0, one task adds the sum of the enabled terms evaluated once at x = `x_point`.
- R4: With `mode` = 1 and `x_first` ≤ `x_final`, one task adds the sum of the enabled terms for every integer x from `x_first` to `x_final` inclusive. The variable does not wrap, even when `x_final` is 65535.
- R5: With `mode` = 1 and `x_first` > `x_final`, a task adds nothing, but still ends with a `done` pulse.
- R6: `start` does not clear the total. Each task adds to the value the previous tasks left in `result`.
- R7: `done` goes high for exactly one cycle. It is high on the cycle after the last term sum of the task has been added, and `result` already holds the final total in that cycle. `result` then stays unchanged until the next task, `finish` or reset.
- R8: A `finish` pulse clears `result` to 0 on the next clock and cancels any task in progress, which then gives no `done`. `finish` takes priority over a `start` in the same cycle.
- R9: A `start` that arrives while a task is still running is ignored. `mode`, `term_sel`, `x_first`, `x_final` and `x_point` are sampled only when a start is accepted, so changing them during a task has no effect.
- R10: Results are exact over the full operand range. For example, x = 65535 with all four terms enabled adds 65535 + 65535² + 65535³ + 65535⁴.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begins a task when the block is idle |
| finish | input | 1 | Clears the total and cancels any task in progress |
| mode | input | 1 | 1 = sweep from first value to last value, 0 = evaluate once at the point value |
| term_sel | input | 4 | Term enables: bit0 x, bit1 x², bit2 x³, bit3 x⁴ |
| x_first | input | 16 | First value of the sweep |
| x_final | input | 16 | Last value of the sweep (inclusive) |
| x_point | input | 16 | Evaluation point in point mode |
| result | output | 200 | Accumulated total |
| done | output | 1 | One-cycle pulse at the end of a task |

## Verification
On every cycle the assertions check these properties:
- While a sweep runs, the variable advances by exactly one with no wrap.
- An empty task (first value above last value) produces only a final marker with no addition.
- The total holds whenever nothing is added.
- `finish` clears the total and suppresses `done`.
- `done` never lasts two cycles.

The arithmetic can only be shown by the bench scenarios, which compare each total against a model computed independently. These scenarios cover:
- each term-select combination;
- point and sweep modes;
- sweeps that reach 65535;
- stacking of tasks without a clear;
- cancellation part-way through a task;
- starts and input changes that arrive while a task is running and must be ignored.

// File: rtl/pwr_integ_pkg.sv
package pwr_integ_pkg;
  localparam int unsigned TERM_N = 4;

  typedef struct packed {
    logic vld;   // token present
    logic add;   // token carries a term sum to accumulate
    logic last;  // final token of the task
  } tok_t;
endpackage

// File: rtl/pwr_integ_mul.sv
module pwr_integ_mul #(
  parameter int unsigned AW = 16,
  parameter int unsigned BW = 16,
  parameter int unsigned PW = AW + BW
) (
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [PW-1:0] p_o
);
  localparam int unsigned OW = (AW > BW) ? AW : BW;
  localparam int unsigned CW = (OW > PW) ? OW : PW;

  logic [CW-1:0] a_ext;
  logic [CW-1:0] b_ext;
  logic [CW-1:0] prod;

  always_comb begin
    a_ext = CW'(a_i);
    b_ext = CW'(b_i);
    prod  = a_ext * b_ext;
    p_o   = prod[PW-1:0];
  end
endmodule

// File: rtl/pwr_integ_ctrl.sv
module pwr_integ_ctrl
  import pwr_integ_pkg::*;
#(
  parameter int unsigned XW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                finish,
  input  logic                drain_i,
  input  logic                mode,
  input  logic [TERM_N-1:0]   sel_i,
  input  logic [XW-1:0]       first_i,
  input  logic [XW-1:0]       final_i,
  input  logic [XW-1:0]       point_i,
  output tok_t                tok_o,
  output logic [XW-1:0]       x_o,
  output logic [TERM_N-1:0]   sel_o,
  output logic                busy_o
);
  logic              busy_q, busy_d;
  logic [XW-1:0]     x_q, x_d;
  logic [XW-1:0]     end_q, end_d;
  logic [TERM_N-1:0] sel_q, sel_d;
  tok_t              tok_q, tok_d;
  logic              accept;
  logic [XW-1:0]     x_inc;

  always_comb begin
    accept = start & ~finish & ~busy_q & ~drain_i;
    x_inc  = x_q + 1'b1;
    busy_d = busy_q;
    x_d    = x_q;
    end_d  = end_q;
    sel_d  = sel_q;
    tok_d  = '0;
    if (finish) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      x_d       = x_inc;
      tok_d.vld = 1'b1;
      tok_d.add = 1'b1;
      tok_d.last = (x_inc == end_q);
      busy_d    = (x_inc != end_q);
    end else if (accept) begin
      sel_d = sel_i;
      end_d = final_i;
      tok_d.vld = 1'b1;
      if (!mode) begin
        x_d        = point_i;
        tok_d.add  = 1'b1;
        tok_d.last = 1'b1;
      end else if (first_i > final_i) begin
        x_d        = first_i;
        tok_d.add  = 1'b0;
        tok_d.last = 1'b1;
      end else begin
        x_d        = first_i;
        tok_d.add  = 1'b1;
        tok_d.last = (first_i == final_i);
        busy_d     = (first_i != final_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      x_q    <= '0;
      end_q  <= '0;
      sel_q  <= '0;
      tok_q  <= '0;
    end else begin
      busy_q <= busy_d;
      x_q    <= x_d;
      end_q  <= end_d;
      sel_q  <= sel_d;
      tok_q  <= tok_d;
    end
  end

  assign tok_o  = tok_q;
  assign x_o    = x_q;
  assign sel_o  = sel_q;
  assign busy_o = busy_q;

  // R4
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !finish) |=> (tok_q.vld && tok_q.add && (x_q == $past(x_q) + 1)));

  // R5
  empty_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_q.vld && !tok_q.add) |-> (tok_q.last && !busy_q));
endmodule

// File: rtl/pwr_integ_chain.sv
module pwr_integ_chain
  import pwr_integ_pkg::*;
#(
  parameter int unsigned XW    = 16,
  parameter int unsigned SUM_W = 4 * XW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               finish,
  input  tok_t               tok_i,
  input  logic [XW-1:0]      x_i,
  input  logic [TERM_N-1:0]  sel_i,
  output tok_t               tok_o,
  output logic [SUM_W-1:0]   sum_o
);
  localparam int unsigned W2 = 2 * XW;
  localparam int unsigned W4 = 4 * XW;

  logic [W2-1:0] sq;
  logic [W4-1:0] cube;
  logic [W4-1:0] quart;
  logic [W4-1:0] pw [TERM_N];
  logic [W4-1:0] term [TERM_N];
  logic [SUM_W-1:0] sum_d, sum_q;
  tok_t tok_d, tok_q;

  pwr_integ_mul #(.AW(XW), .BW(XW), .PW(W2)) u_mul_sq (
    .a_i(x_i), .b_i(x_i), .p_o(sq));

  pwr_integ_mul #(.AW(W2), .BW(W2), .PW(W4)) u_mul_cube (
    .a_i(sq), .b_i(W2'(x_i)), .p_o(cube));

  pwr_integ_mul #(.AW(W4), .BW(W4), .PW(W4)) u_mul_quart (
    .a_i(W4'(sq)), .b_i(W4'(sq)), .p_o(quart));

  assign pw[0] = W4'(x_i);
  assign pw[1] = W4'(sq);
  assign pw[2] = cube;
  assign pw[3] = quart;

  for (genvar k = 0; k < TERM_N; k++) begin : g_term
    assign term[k] = sel_i[k] ? pw[k] : '0;
  end

  always_comb begin
    sum_d = '0;
    for (int k = 0; k < TERM_N; k++) begin
      sum_d = sum_d + SUM_W'(term[k]);
    end
    tok_d = finish ? '0 : tok_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= '0;
      sum_q <= '0;
    end else begin
      tok_q <= tok_d;
      if (tok_i.vld) begin
        sum_q <= sum_d;
      end
    end
  end

  assign tok_o = tok_q;
  assign sum_o = sum_q;

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !tok_q.vld);
endmodule

// File: rtl/pwr_integ_acc.sv
module pwr_integ_acc
  import pwr_integ_pkg::*;
#(
  parameter int unsigned SUM_W = 66,
  parameter int unsigned ACC_W = 200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               finish,
  input  tok_t               tok_i,
  input  logic [SUM_W-1:0]   sum_i,
  output logic [ACC_W-1:0]   acc_o,
  output logic               done_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             done_q, done_d;
  logic             acc_en;

  always_comb begin
    acc_en = finish | (tok_i.vld & tok_i.add);
    acc_d  = finish ? '0 : (acc_q + ACC_W'(sum_i));
    done_d = ~finish & tok_i.vld & tok_i.last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (acc_en) begin
        acc_q <= acc_d;
      end
      done_q <= done_d;
    end
  end

  assign acc_o  = acc_q;
  assign done_o = done_q;

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (acc_q == '0 && !done_q));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!finish && !(tok_i.vld && tok_i.add)) |=> $stable(acc_q));
endmodule

// File: rtl/pwr_series_integ.sv
module pwr_series_integ
  import pwr_integ_pkg::*;
#(
  parameter int unsigned XW    = 16,
  parameter int unsigned ACC_W = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              finish,
  input  logic              mode,
  input  logic [3:0]        term_sel,
  input  logic [XW-1:0]     x_first,
  input  logic [XW-1:0]     x_final,
  input  logic [XW-1:0]     x_point,
  output logic [ACC_W-1:0]  result,
  output logic              done
);
  localparam int unsigned SUM_W = 4 * XW + 2;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  tok_t              c_tok, s_tok;
  logic [XW-1:0]     c_x;
  logic [TERM_N-1:0] c_sel;
  logic              c_busy;
  logic              drain;
  logic [SUM_W-1:0]  s_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign drain = c_tok.vld | s_tok.vld;

  pwr_integ_ctrl #(.XW(XW)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start), .finish(finish),
    .drain_i(drain), .mode(mode), .sel_i(term_sel),
    .first_i(x_first), .final_i(x_final), .point_i(x_point),
    .tok_o(c_tok), .x_o(c_x), .sel_o(c_sel), .busy_o(c_busy));

  pwr_integ_chain #(.XW(XW), .SUM_W(SUM_W)) u_chain (
    .clk(clk), .rst_n(rst_int_n), .finish(finish),
    .tok_i(c_tok), .x_i(c_x), .sel_i(c_sel),
    .tok_o(s_tok), .sum_o(s_sum));

  pwr_integ_acc #(.SUM_W(SUM_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_int_n), .finish(finish),
    .tok_i(s_tok), .sum_i(s_sum), .acc_o(result), .done_o(done));

  // R9
  busy_drain_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (c_busy && !finish) |=> c_tok.vld);

  // R1
  reset_chk: assert property (@(posedge clk) !rst_int_n |-> (result == '0 && !done));
endmodule

// File: tb/tb_pwr_series_integ.sv
module tb_pwr_series_integ;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         finish = 1'b0;
  logic         mode = 1'b0;
  logic [3:0]   term_sel = 4'b0;
  logic [15:0]  x_first = '0;
  logic [15:0]  x_final = '0;
  logic [15:0]  x_point = '0;
  logic [199:0] result;
  logic         done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit mon_en = 1'b0;
  bit done_prev = 1'b0;
  logic [199:0] exp_acc = '0;
  logic [199:0] exp_q [$];
  string        tag_q [$];

  always #2 clk = ~clk;

  pwr_series_integ dut (
    .clk(clk), .rst_n(rst_n), .start(start), .finish(finish), .mode(mode),
    .term_sel(term_sel), .x_first(x_first), .x_final(x_final),
    .x_point(x_point), .result(result), .done(done));

  task automatic chk(input bit ok, input string req,
                     input logic [199:0] act, input logic [199:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [199:0] fval(input logic [3:0] s, input int x);
    logic [199:0] v, p2, r;
    v  = 200'(x);
    p2 = v * v;
    r  = '0;
    if (s[0]) r = r + v;
    if (s[1]) r = r + p2;
    if (s[2]) r = r + p2 * v;
    if (s[3]) r = r + p2 * p2;
    return r;
  endfunction

  function automatic logic [199:0] task_sum(input bit md, input logic [3:0] s,
                                            input int m, input int n, input int c);
    logic [199:0] r;
    r = '0;
    if (!md) r = fval(s, c);
    else for (int x = m; x <= n; x++) r = r + fval(s, x);
    return r;
  endfunction

  task automatic pulse_start(input bit md, input logic [3:0] s,
                             input int m, input int n, input int c);
    @(negedge clk);
    mode = md; term_sel = s;
    x_first = 16'(m); x_final = 16'(n); x_point = 16'(c);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input string req, input bit md, input logic [3:0] s,
                     input int m, input int n, input int c);
    exp_acc = exp_acc + task_sum(md, s, m, n, c);
    exp_q.push_back(exp_acc);
    tag_q.push_back(req);
    pulse_start(md, s, m, n, c);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_finish();
    @(negedge clk);
    finish = 1'b1;
    @(negedge clk);
    finish = 1'b0;
    exp_acc = '0;
  endtask

  // monitor: pops expected totals as done pulses appear
  always @(negedge clk) begin
    if (mon_en) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8/R9 unexpected done", result, exp_acc);
        end else begin
          logic [199:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(result == e, t, result, e);
        end
        chk(!done_prev, "R7 done single cycle", 200'(done_prev), 200'(0));
      end
      done_prev = done;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(result == '0 && !done, "R1 in reset", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result == '0 && !done, "R1 after release", result, '0);
    repeat (3) @(negedge clk);
    mon_en = 1'b1;

    // R3 point mode, R2 all terms
    run("R3 point c=3 all terms", 1'b0, 4'b1111, 0, 0, 3);
    // R6 stacks on previous total
    run("R6 stack point c=7 x^2", 1'b0, 4'b0010, 0, 0, 7);
    // R2 individual terms
    do_finish();
    run("R2 only x", 1'b0, 4'b0001, 0, 0, 11);
    run("R2 only x^3", 1'b0, 4'b0100, 0, 0, 11);
    run("R2 only x^4", 1'b0, 4'b1000, 0, 0, 11);
    run("R2 none selected adds zero", 1'b0, 4'b0000, 0, 0, 500);
    // R10 max operand
    do_finish();
    run("R10 c=65535 all terms", 1'b0, 4'b1111, 0, 0, 65535);
    // R4 sweep
    do_finish();
    run("R4 sweep 1..10 x", 1'b1, 4'b0001, 1, 10, 0);
    run("R4 sweep 0..40 x^2+x^3", 1'b1, 4'b0110, 0, 40, 0);
    run("R4 sweep m==n", 1'b1, 4'b1111, 9, 9, 0);
    run("R4 sweep to 65535 no wrap", 1'b1, 4'b1111, 65530, 65535, 0);
    // R5 empty sweep
    run("R5 m>n adds nothing", 1'b1, 4'b1111, 20, 5, 0);

    // R7 result holds after done
    repeat (6) @(negedge clk);
    chk(result == exp_acc, "R7 result holds", result, exp_acc);

    // R9 start and input changes during a sweep ignored
    exp_acc = exp_acc + task_sum(1'b1, 4'b0011, 0, 60, 0);
    exp_q.push_back(exp_acc);
    tag_q.push_back("R9 busy start ignored");
    pulse_start(1'b1, 4'b0011, 0, 60, 0);
    repeat (4) @(negedge clk);
    pulse_start(1'b0, 4'b1111, 0, 0, 999);
    mode = 1'b1; term_sel = 4'b1000; x_first = 16'd3; x_final = 16'd4000;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(result == exp_acc, "R9 changed inputs no effect", result, exp_acc);

    // R8 finish cancels a running sweep
    pulse_start(1'b1, 4'b1111, 0, 200, 0);
    repeat (10) @(negedge clk);
    do_finish();
    repeat (250) @(negedge clk);
    chk(result == '0, "R8 finish clears and cancels", result, '0);

    // R8 finish beats start in the same cycle
    run("R8 refill", 1'b0, 4'b0001, 0, 0, 77);
    @(negedge clk);
    mode = 1'b0; term_sel = 4'b1111; x_point = 16'd5;
    start = 1'b1; finish = 1'b1;
    @(negedge clk);
    start = 1'b0; finish = 1'b0;
    exp_acc = '0;
    repeat (8) @(negedge clk);
    chk(result == '0, "R8 finish priority over start", result, '0);

    // R6 accumulation after clear
    run("R6 after clear", 1'b1, 4'b1001, 2, 6, 0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule